// File: doc/BRIEF.md
# Wired Translation Lookaside Buffer

This block is a small, fully associative cache of page-to-frame translations. The current address-space identifier and a virtual page number are compared against every stored entry in parallel. The hit flag and the frame number come back combinationally in the same cycle. When a lookup misses, the page-table walker outside the block installs the missing pair through the fill port. Once installed, later lookups of that page hit.

Any entry can be pinned when it is filled, so that it survives both replacement and flushes. This suits translations that must always be present, such as kernel code. A free-running counter picks the replacement victim: the search starts at the counter position and skips pinned slots. Empty slots are always used before any valid entry is evicted.

A flush removes every unpinned translation in one cycle. This is used when a new address space is scheduled. Two wrapping counters record the lookups that hit and the lookups that missed, so the hit ratio can be measured.

Top module: `tlb_wired`

## Requirements
- R1: After reset no entry is valid, every lookup misses, and both event counters read zero.
- R2: With lk_valid high, lk_hit, lk_miss and lk_pfn reflect the stored contents in the same cycle. lk_pfn is zero on a miss.
- R3: A lookup of a page that has not been installed misses. After a fill of that page and frame under the current identifier, lookups of it hit and return that frame.
- R4: A hit requires both the stored page and the stored identifier to equal lk_vpn and cur_asid. The same page under another identifier misses.
- R5: A fill whose page and identifier are already present rewrites that entry's frame in place. No second copy is made, and no other entry is displaced. The pin flag becomes the old flag OR fill_wire.
- R6: While any slot is invalid, a fill installs into an invalid slot. Filling ENTRIES distinct pages into an empty buffer keeps all of them.
- R7: When every slot is valid, a fill of a new page replaces exactly one entry, and the new page hits afterwards.
- R8: A pinned entry is never chosen as a replacement victim.
- R9: If a new page is filled while every slot is pinned, fill_err is high in that same cycle and the buffer contents do not change.
- R10: A flush_req pulse invalidates all unpinned entries at the next clock edge. Pinned entries stay valid.
- R11: An unpin_req pulse clears every pin flag and leaves the entries valid, so that a later flush removes them.
- R12: hit_cnt and miss_cnt each rise by one, one cycle after a lookup with lk_valid high that hit or missed respectively.
- R13: A lookup in the same cycle as a fill sees the contents as they were before that fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_asid | input | ASID_W | Current address-space identifier, used by both lookup and fill |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_miss | output | 1 | Lookup found no matching entry |
| lk_pfn | output | PFN_W | Frame number of the hit, zero otherwise |
| fill_en | input | 1 | Install or update a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_wire | input | 1 | Pin the installed entry |
| fill_err | output | 1 | Fill rejected because every slot is pinned |
| flush_req | input | 1 | Invalidate all unpinned entries |
| unpin_req | input | 1 | Clear all pin flags |
| hit_cnt | output | CNT_W | Wrapping count of hits |
| miss_cnt | output | CNT_W | Wrapping count of misses |

## Verification
The entries are not visible at the ports. A wrong valid, pin or key bit therefore shows up only in the next lookup that touches that slot. The bench exposes such faults by sweeping every page number under a given identifier after each operation, counting the hits and comparing each returned frame with an arithmetic function of page and identifier. A victim choice that lands on a pinned slot, a flush that leaves or clears the wrong entries, or a duplicate created by an update all change that hit count in the sweep that follows, one cycle after the edge at fault. A counter fault is seen one cycle after the lookup that should have counted.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // Kind of write the store performs at the next edge
   typedef enum logic [1:0] {
      WR_NONE    = 2'd0,
      WR_UPDATE  = 2'd1,
      WR_INSTALL = 2'd2
   } tlb_wr_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int N     = 8,
   parameter int KEY_W = 12,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]            valid,
   input  logic [N-1:0][KEY_W-1:0] keys,
   input  logic [KEY_W-1:0]        probe,
   output logic [N-1:0]            match,
   output logic                    any,
   output logic [IDX_W-1:0]        idx
);

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g] = valid[g] && (keys[g] == probe);
   end

   assign any = |match;

   // OR-encode; at most one bit is set
   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (match[i]) idx = idx | IDX_W'(i);
      end
   end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int N = 8,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     valid,
   input  logic [N-1:0]     wired,
   output logic [IDX_W-1:0] idx,
   output logic             ok
);

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] rot_idx;
   logic [IDX_W-1:0] cand;
   logic             free_found;
   logic             rot_found;

   // Free-running pointer; N is a power of two so it wraps naturally
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_q + 1'b1;
   end

   // Lowest-index invalid slot
   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            free_found = 1'b1;
            free_idx   = IDX_W'(i);
         end
      end
   end

   // First unpinned slot at or after the pointer
   always_comb begin
      rot_found = 1'b0;
      rot_idx   = '0;
      cand      = '0;
      for (int k = N - 1; k >= 0; k--) begin
         cand = ptr_q + IDX_W'(k);
         if (!wired[cand]) begin
            rot_found = 1'b1;
            rot_idx   = cand;
         end
      end
   end

   assign ok  = free_found | rot_found;
   assign idx = free_found ? free_idx : rot_idx;

endmodule

// File: rtl/tlb_store.sv
module tlb_store
   import tlb_pkg::*;
#(
   parameter int N     = 8,
   parameter int KEY_W = 12,
   parameter int PFN_W = 8,
   localparam int IDX_W = $clog2(N)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush,
   input  logic                    unpin,
   input  tlb_wr_e                 wr_kind,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [KEY_W-1:0]        wr_key,
   input  logic [PFN_W-1:0]        wr_pfn,
   input  logic                    wr_wire,
   output logic [N-1:0]            valid_q,
   output logic [N-1:0]            wired_q,
   output logic [N-1:0][KEY_W-1:0] keys_q,
   output logic [N-1:0][PFN_W-1:0] pfns_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         wired_q <= '0;
         keys_q  <= '0;
         pfns_q  <= '0;
      end else begin
         if (flush) valid_q <= valid_q & wired_q;
         if (unpin) wired_q <= '0;
         // A write in the same cycle takes precedence for its slot
         case (wr_kind)
            WR_INSTALL: begin
               valid_q[wr_idx] <= 1'b1;
               wired_q[wr_idx] <= wr_wire;
               keys_q[wr_idx]  <= wr_key;
               pfns_q[wr_idx]  <= wr_pfn;
            end
            WR_UPDATE: begin
               valid_q[wr_idx] <= 1'b1;
               wired_q[wr_idx] <= wr_wire | (wired_q[wr_idx] & ~unpin);
               pfns_q[wr_idx]  <= wr_pfn;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/tlb_wired.sv
module tlb_wired
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 8,
   parameter int PFN_W   = 8,
   parameter int ASID_W  = 4,
   parameter int CNT_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic [PFN_W-1:0]  lk_pfn,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic              fill_wire,
   output logic              fill_err,
   input  logic              flush_req,
   input  logic              unpin_req,
   output logic [CNT_W-1:0]  hit_cnt,
   output logic [CNT_W-1:0]  miss_cnt
);

   localparam int KEY_W = ASID_W + VPN_W;
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("tlb_wired: ENTRIES must be a power of two, at least 2");
   end
   if (VPN_W < 1 || PFN_W < 1 || ASID_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("tlb_wired: all widths must be positive");
   end

   logic [ENTRIES-1:0]            st_valid;
   logic [ENTRIES-1:0]            st_wired;
   logic [ENTRIES-1:0][KEY_W-1:0] st_keys;
   logic [ENTRIES-1:0][PFN_W-1:0] st_pfns;

   logic [ENTRIES-1:0] lk_match;
   logic               lk_any;
   logic [IDX_W-1:0]   lk_idx;
   logic [ENTRIES-1:0] fl_match;
   logic               fl_any;
   logic [IDX_W-1:0]   fl_idx;
   logic [IDX_W-1:0]   vic_idx;
   logic               vic_ok;
   tlb_wr_e            wr_kind;
   logic [IDX_W-1:0]   wr_idx;

   tlb_cam #(.N(ENTRIES), .KEY_W(KEY_W)) u_lk_cam (
      .valid (st_valid),
      .keys  (st_keys),
      .probe ({cur_asid, lk_vpn}),
      .match (lk_match),
      .any   (lk_any),
      .idx   (lk_idx)
   );

   tlb_cam #(.N(ENTRIES), .KEY_W(KEY_W)) u_fl_cam (
      .valid (st_valid),
      .keys  (st_keys),
      .probe ({cur_asid, fill_vpn}),
      .match (fl_match),
      .any   (fl_any),
      .idx   (fl_idx)
   );

   tlb_victim #(.N(ENTRIES)) u_victim (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (st_valid),
      .wired (st_wired),
      .idx   (vic_idx),
      .ok    (vic_ok)
   );

   always_comb begin
      wr_kind = WR_NONE;
      if (fill_en) begin
         if (fl_any)      wr_kind = WR_UPDATE;
         else if (vic_ok) wr_kind = WR_INSTALL;
      end
   end

   assign wr_idx   = fl_any ? fl_idx : vic_idx;
   assign fill_err = fill_en && !fl_any && !vic_ok;

   tlb_store #(.N(ENTRIES), .KEY_W(KEY_W), .PFN_W(PFN_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush_req),
      .unpin   (unpin_req),
      .wr_kind (wr_kind),
      .wr_idx  (wr_idx),
      .wr_key  ({cur_asid, fill_vpn}),
      .wr_pfn  (fill_pfn),
      .wr_wire (fill_wire),
      .valid_q (st_valid),
      .wired_q (st_wired),
      .keys_q  (st_keys),
      .pfns_q  (st_pfns)
   );

   assign lk_hit  = lk_valid && lk_any;
   assign lk_miss = lk_valid && !lk_any;
   assign lk_pfn  = lk_any ? st_pfns[lk_idx] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_cnt  <= '0;
         miss_cnt <= '0;
      end else begin
         if (lk_hit)  hit_cnt  <= hit_cnt + 1'b1;
         if (lk_miss) miss_cnt <= miss_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/tlb_wired_chk.sv
module tlb_wired_chk #(
   parameter int N     = 8,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N-1:0]     st_valid,
   input logic [N-1:0]     st_wired,
   input logic [N-1:0]     lk_match,
   input logic             lk_hit,
   input logic             lk_miss,
   input logic             fill_en,
   input logic             fill_err,
   input logic             flush_req,
   input logic             unpin_req,
   input logic [CNT_W-1:0] hit_cnt,
   input logic [CNT_W-1:0] miss_cnt
);

   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match)); // R5

   AST_PINNED_SURVIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !unpin_req |=> (($past(st_wired) & ~st_valid) == '0)); // R8

   AST_FLUSH_KEEPS_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req && !fill_en && !unpin_req) |=> (st_valid == $past(st_wired))); // R10

   AST_REJECT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      fill_err |-> ((&st_wired) && (&st_valid))); // R9

   AST_REJECT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_err && !flush_req && !unpin_req) |=>
         (st_valid == $past(st_valid) && st_wired == $past(st_wired))); // R9

   AST_HIT_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |=> (hit_cnt == $past(hit_cnt) + CNT_W'(1))); // R12

   AST_MISS_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss |=> (miss_cnt == $past(miss_cnt) + CNT_W'(1))); // R12

endmodule

bind tlb_wired tlb_wired_chk #(.N(ENTRIES), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st_valid  (st_valid),
   .st_wired  (st_wired),
   .lk_match  (lk_match),
   .lk_hit    (lk_hit),
   .lk_miss   (lk_miss),
   .fill_en   (fill_en),
   .fill_err  (fill_err),
   .flush_req (flush_req),
   .unpin_req (unpin_req),
   .hit_cnt   (hit_cnt),
   .miss_cnt  (miss_cnt)
);

// File: tb/tlb_wired_bench.sv
module tlb_wired_bench;

   localparam int CLK_PERIOD = 10;
   localparam int VPN_W = 8;
   localparam int PFN_W = 8;
   localparam int ASID_W = 4;
   localparam int CNT_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ASID_W-1:0] cur_asid = '0;
   logic              lk_valid = 1'b0;
   logic [VPN_W-1:0]  lk_vpn = '0;
   logic              lk_hit, lk_miss, fill_err;
   logic [PFN_W-1:0]  lk_pfn;
   logic              fill_en = 1'b0;
   logic [VPN_W-1:0]  fill_vpn = '0;
   logic [PFN_W-1:0]  fill_pfn = '0;
   logic              fill_wire = 1'b0;
   logic              flush_req = 1'b0;
   logic              unpin_req = 1'b0;
   logic [CNT_W-1:0]  hit_cnt, miss_cnt;

   int n_tests = 0;
   int n_fail = 0;
   int exp_hits = 0;
   int exp_miss = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tlb_wired u_tlb_wired (
      .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_miss(lk_miss),
      .lk_pfn(lk_pfn), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
      .fill_wire(fill_wire), .fill_err(fill_err), .flush_req(flush_req),
      .unpin_req(unpin_req), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
   );

   function automatic logic [PFN_W-1:0] frame_of(input int v, input int a);
      return PFN_W'(v * 5 + a * 17 + 3);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic lookup(input int v, input int a, output bit hit, output int pfn);
      @(negedge clk);
      cur_asid = ASID_W'(a);
      lk_vpn   = VPN_W'(v);
      lk_valid = 1'b1;
      #1;
      hit = lk_hit;
      pfn = int'(lk_pfn);
      if (lk_hit) exp_hits++; else exp_miss++;
      @(posedge clk);
      #1 lk_valid = 1'b0;
   endtask

   task automatic fill(input int v, input int a, input int pfn, input bit wire_it,
                       output bit err);
      @(negedge clk);
      cur_asid  = ASID_W'(a);
      fill_vpn  = VPN_W'(v);
      fill_pfn  = PFN_W'(pfn);
      fill_wire = wire_it;
      fill_en   = 1'b1;
      #1 err = fill_err;
      @(negedge clk);
      fill_en   = 1'b0;
      fill_wire = 1'b0;
   endtask

   task automatic pulse_flush();
      @(negedge clk);
      flush_req = 1'b1;
      @(negedge clk);
      flush_req = 1'b0;
   endtask

   task automatic pulse_unpin();
      @(negedge clk);
      unpin_req = 1'b1;
      @(negedge clk);
      unpin_req = 1'b0;
   endtask

   task automatic sweep(input int a, output int hits, output int bad);
      bit h;
      int p;
      hits = 0;
      bad  = 0;
      for (int v = 0; v < (1 << VPN_W); v++) begin
         lookup(v, a, h, p);
         if (h) begin
            hits++;
            if (p != int'(frame_of(v, a))) bad++;
         end else if (p != 0) begin
            bad++;
         end
      end
   endtask

   task automatic expect_hit(input string req, input int v, input int a);
      bit h;
      int p;
      lookup(v, a, h, p);
      chk(req, int'(h), 1);
      chk(req, p, int'(frame_of(v, a)));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      bit h, e;
      int p, hits, bad;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: empty after reset
      chk("R1 hit_cnt", int'(hit_cnt), 0);
      chk("R1 miss_cnt", int'(miss_cnt), 0);
      sweep(0, hits, bad);
      chk("R1 hits after reset", hits, 0);
      chk("R2 pfn zero on miss", bad, 0);
      @(negedge clk);
      chk("R12 miss count", int'(miss_cnt), exp_miss);

      // R3 / R2: miss, fill, hit
      lookup(8'h10, 1, h, p);
      chk("R3 miss before fill", int'(h), 0);
      fill(8'h10, 1, int'(frame_of(8'h10, 1)), 1'b0, e);
      chk("R3 fill accepted", int'(e), 0);
      expect_hit("R3 R2 hit after fill", 8'h10, 1);

      // R4: identifier must match
      lookup(8'h10, 2, h, p);
      chk("R4 other asid misses", int'(h), 0);

      // R13: lookup in the fill cycle sees old contents
      @(negedge clk);
      cur_asid  = 4'd1;
      lk_vpn    = 8'h20;
      lk_valid  = 1'b1;
      fill_vpn  = 8'h20;
      fill_pfn  = frame_of(8'h20, 1);
      fill_en   = 1'b1;
      #1;
      chk("R13 same-cycle miss", int'(lk_hit), 0);
      exp_miss++;
      @(posedge clk);
      #1;
      lk_valid = 1'b0;
      fill_en  = 1'b0;
      expect_hit("R13 hit next cycle", 8'h20, 1);

      // R6: fill to capacity, nothing lost
      for (int i = 3; i <= 8; i++) begin
         fill(i * 16, 1, int'(frame_of(i * 16, 1)), 1'b0, e);
         chk("R6 fill accepted", int'(e), 0);
      end
      sweep(1, hits, bad);
      chk("R6 all entries kept", hits, 8);
      chk("R6 frames correct", bad, 0);
      sweep(0, hits, bad);
      chk("R4 asid0 sees none", hits, 0);

      // R5: duplicate fill updates in place
      fill(8'h30, 1, int'(frame_of(8'h30, 1)) ^ 8'hFF, 1'b0, e);
      lookup(8'h30, 1, h, p);
      chk("R5 updated frame", p, int'(frame_of(8'h30, 1)) ^ 8'hFF);
      sweep(1, hits, bad);
      chk("R5 no eviction", hits, 8);
      chk("R5 one changed frame", bad, 1);
      fill(8'h30, 1, int'(frame_of(8'h30, 1)), 1'b0, e);

      // R8 / R7: pin three, then churn
      for (int i = 1; i <= 3; i++) fill(i * 16, 1, int'(frame_of(i * 16, 1)), 1'b1, e);
      fill(8'h90, 1, int'(frame_of(8'h90, 1)), 1'b0, e);
      chk("R7 fill into full buffer", int'(e), 0);
      expect_hit("R7 new page hits", 8'h90, 1);
      sweep(1, hits, bad);
      chk("R7 exactly one replaced", hits, 8);
      chk("R7 frames correct", bad, 0);
      for (int i = 1; i < 20; i++) begin
         fill(8'h90 + i, 1, int'(frame_of(8'h90 + i, 1)), 1'b0, e);
         chk("R7 churn accepted", int'(e), 0);
      end
      expect_hit("R7 last install hits", 8'hA3, 1);
      for (int i = 1; i <= 3; i++) expect_hit("R8 pinned survives", i * 16, 1);
      sweep(1, hits, bad);
      chk("R7 occupancy stays full", hits, 8);

      // R10: flush keeps pinned only
      pulse_flush();
      sweep(1, hits, bad);
      chk("R10 pinned left", hits, 3);
      chk("R10 frames correct", bad, 0);
      for (int i = 1; i <= 3; i++) expect_hit("R10 pinned entry", i * 16, 1);

      // R9: fill every slot pinned, then reject
      for (int i = 0; i < 5; i++) begin
         fill(8'hE0 + i, 1, int'(frame_of(8'hE0 + i, 1)), 1'b1, e);
         chk("R9 pinned fill accepted", int'(e), 0);
      end
      fill(8'hF0, 1, int'(frame_of(8'hF0, 1)), 1'b0, e);
      chk("R9 reject flag", int'(e), 1);
      lookup(8'hF0, 1, h, p);
      chk("R9 rejected page absent", int'(h), 0);
      sweep(1, hits, bad);
      chk("R9 contents unchanged", hits, 8);

      // R11: unpin then flush empties
      pulse_unpin();
      sweep(1, hits, bad);
      chk("R11 still valid", hits, 8);
      pulse_flush();
      sweep(1, hits, bad);
      chk("R11 flushed after unpin", hits, 0);

      // R12: counters agree with bench tallies
      @(negedge clk);
      chk("R12 hit_cnt", int'(hit_cnt), exp_hits & 16'hFFFF);
      chk("R12 miss_cnt", int'(miss_cnt), exp_miss & 16'hFFFF);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule